// File: doc/BRIEF.md
# Synchronous DRAM Access Controller

This block sits between a single in-order requester and a multi-bank synchronous DRAM. It takes one read or write request at a time over a valid/ready port. It breaks each request into clocked DRAM commands on a shared multiplexed address bus: a row activation that carries the row address, then a column command that carries the column address. Each bank keeps its row open after an access. A later request to the same row goes straight to a column command. A request to another row first closes the bank with a precharge.

Read data comes back from the DRAM a fixed number of cycles after the column command. It arrives as a burst of consecutive words, and a two-bit setting picks the burst length. The controller captures each beat and hands it to the requester with a per-beat strobe, in request order. It may issue a row activation or precharge for one bank while another bank is still returning a burst. A free-running interval counter schedules refresh: once refresh is due, the controller stops starting new requests, lets reads drain, closes all banks and issues a refresh.

Top module: `sdc_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the command output is idle (code 0), `rsp_valid` is low and `req_ready` is low.
- R2: The request address is split as {row, bank, column} from most to least significant bit. The activate command carries the row on `dram_addr`, and the column command carries the column on the same bus for the same bank.
- R3: A read or write column command to a bank comes at least T_RCD cycles after that bank's activate.
- R4: The first read beat appears on `rsp_valid`/`rsp_data` exactly CAS_LAT+1 cycles after the read command cycle. Each further beat follows on the next cycle.
- R5: A read returns 2^`cfg_burst` beats (1, 2, 4 or 8), sampled when the request is accepted. Beats from different reads never overlap and come back in request order.
- R6: A request to the row already open in its bank is served with a column command alone, with no activate or precharge.
- R7: A request to a bank whose open row differs first precharges that bank. The activate comes at least T_RP cycles later. No bank is activated while a row is already open in it.
- R8: A row command for one bank may be issued while read beats of another bank are still being delivered on `rsp_valid`.
- R9: A refresh (code 6) is issued only when every bank is closed and no read beat is still outstanding. An all-bank precharge (code 5) closes any open rows first.
- R10: Refresh comes due every REFI cycles and takes priority over waiting requests, so refreshes keep their period under a continuous request stream.
- R11: A write sends one word: the write command (code 3) carries `req_wdata` on `dram_wdata` and is held back until no read beat is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst | input | 2 | Read burst length code, beats = 2^code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | Word address {row, bank, column} |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read beat strobe |
| rsp_data | output | DATA_W | Read beat data |
| dram_cmd | output | 3 | 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge all, 6 refresh |
| dram_bank | output | BANK_W | Bank for the command |
| dram_addr | output | max(ROW_W,COL_W) | Row or column address |
| dram_wdata | output | DATA_W | Write word with the write command |
| dram_rdata | input | DATA_W | Read data from the DRAM |

## Verification
Two events can land in the same cycle: refresh coming due and a request waiting that is ready to go. Page-hit reads arrive back to back at full rate for several refresh intervals, so every due point lands while a request is waiting and a read is in flight. The bench judges this by the spacing of refreshes, which must stay within a small margin of REFI. At each refresh it also checks that its bank model shows every row closed and no expected beat outstanding.

// File: rtl/sdc_pkg.sv
// Shared command codes and helpers for the synchronous DRAM controller.
// Assumes burst codes of 0..3 (1 to 8 beats).
package sdc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PALL = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    // beats in a read burst for a burst code
    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/sdc_bank_state.sv
// Per-bank state: open flag, open row and a gap timer.
// The timer is loaded after an activate (T_RCD) or precharge (T_RP) and
// must reach zero before the next command to this bank. Assumes T_RCD, T_RP >= 1.
module sdc_bank_state #(
    parameter int ROW_W = 8,
    parameter int TMR_W = 3,
    parameter int T_RCD = 2,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic             pre_en,
    input  logic             col_en,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             ready
);
    logic [TMR_W-1:0] tmr;

    // track open row and count down the bank's minimum command gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
            tmr      <= '0;
        end else if (act_en) begin
            is_open  <= 1'b1;
            open_row <= act_row;
            tmr      <= TMR_W'(T_RCD - 1);
        end else if (pre_en) begin
            is_open  <= 1'b0;
            tmr      <= TMR_W'(T_RP - 1);
        end else if (tmr != '0) begin
            tmr      <= tmr - 1'b1;
        end
    end

    assign ready = (tmr == '0);

    // R3
    col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_en |-> (is_open && ready));
    // R7
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> (!is_open && ready));
endmodule

// File: rtl/sdc_refresh_timer.sv
// Free-running refresh interval counter. Raises due every REFI cycles and
// holds it until the controller acknowledges with a refresh command.
module sdc_refresh_timer #(
    parameter int REFI = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CNT_W = $clog2(REFI);
    logic [CNT_W-1:0] cnt;

    // count the interval and latch a pending refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            if (cnt == CNT_W'(REFI - 1)) begin
                cnt <= '0;
                due <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end

    // R10
    ack_only_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> due);
endmodule

// File: rtl/sdc_read_return.sv
// Read return path: delays each read launch by CAS_LAT cycles, then
// captures the burst beats from the DRAM and presents them registered.
// Assumes launches are spaced by at least the previous burst length.
module sdc_read_return #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 3,
    parameter int BL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BL_W-1:0]   launch_bl,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              busy
);
    logic [CAS_LAT-1:0] sr_v;
    logic [BL_W-1:0]    sr_bl [CAS_LAT];
    logic [BL_W-1:0]    cnt;

    // shift launches through the CAS latency delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_v <= '0;
            for (int i = 0; i < CAS_LAT; i++) sr_bl[i] <= '0;
        end else begin
            sr_v[0]  <= launch;
            sr_bl[0] <= launch_bl;
            for (int i = 1; i < CAS_LAT; i++) begin
                sr_v[i]  <= sr_v[i-1];
                sr_bl[i] <= sr_bl[i-1];
            end
        end
    end

    // count remaining beats and capture each one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (sr_v[CAS_LAT-1]) cnt <= sr_bl[CAS_LAT-1];
            else if (cnt != '0)  cnt <= cnt - 1'b1;
            rsp_valid <= (cnt != '0);
            if (cnt != '0) rsp_data <= dram_rdata;
        end
    end

    assign busy = (|sr_v) || (cnt != '0);

    // R5
    no_burst_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_v[CAS_LAT-1] |-> (cnt <= BL_W'(1)));
endmodule

// File: rtl/sdc_ctrl.sv
// Synchronous DRAM access controller top. Serves one request at a time:
// activate / precharge / column command per bank state, refresh with
// priority, read data returned through a CAS-latency pipe. req_ready is
// asserted in the cycle the column command is decided. Assumes the
// requester holds its request stable until accepted.
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 3,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RFC   = 4,
    parameter int REFI    = 400,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_burst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [2:0]        dram_cmd,
    output logic [BANK_W-1:0] dram_bank,
    output logic [DA_W-1:0]   dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    localparam int TMR_W = $clog2(T_RCD + T_RP + T_RFC + 1);
    localparam int BL_W  = 4;

    logic [COL_W-1:0]  r_col;
    logic [BANK_W-1:0] r_bank;
    logic [ROW_W-1:0]  r_row;
    logic [NBANK-1:0]  bk_open, bk_ready;
    logic [ROW_W-1:0]  bk_row [NBANK];
    logic              do_act, do_pre, do_col, do_pall, do_ref;
    logic              ref_due, rd_busy, any_open, all_ready, page_hit;
    logic [BL_W-1:0]   bl_cur;
    logic [BL_W-1:0]   col_wait;
    logic [TMR_W-1:0]  rfc_wait;
    cmd_e              cmd_q;

    assign {r_row, r_bank, r_col} = req_addr;
    assign bl_cur    = burst_beats(cfg_burst);
    assign any_open  = |bk_open;
    assign all_ready = &bk_ready;
    assign page_hit  = bk_open[r_bank] && (bk_row[r_bank] == r_row);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdc_bank_state #(.ROW_W(ROW_W), .TMR_W(TMR_W), .T_RCD(T_RCD), .T_RP(T_RP)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_en   (do_act && (r_bank == BANK_W'(g))),
            .pre_en   (do_pall || (do_pre && (r_bank == BANK_W'(g)))),
            .col_en   (do_col && (r_bank == BANK_W'(g))),
            .act_row  (r_row),
            .is_open  (bk_open[g]),
            .open_row (bk_row[g]),
            .ready    (bk_ready[g])
        );
    end

    sdc_refresh_timer #(.REFI(REFI)) refresh_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (do_ref),
        .due   (ref_due)
    );

    sdc_read_return #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .BL_W(BL_W)) return_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (do_col && !req_write),
        .launch_bl  (bl_cur),
        .dram_rdata (dram_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .busy       (rd_busy)
    );

    // choose this cycle's command: refresh first, then the waiting request
    always_comb begin
        do_act  = 1'b0;
        do_pre  = 1'b0;
        do_col  = 1'b0;
        do_pall = 1'b0;
        do_ref  = 1'b0;
        if (rfc_wait == '0) begin
            if (ref_due) begin
                if (!rd_busy && all_ready) begin
                    if (any_open) do_pall = 1'b1;
                    else          do_ref  = 1'b1;
                end
            end else if (req_valid && bk_ready[r_bank]) begin
                if (!bk_open[r_bank])  do_act = 1'b1;
                else if (!page_hit)    do_pre = 1'b1;
                else if (col_wait == '0 && (!req_write || !rd_busy)) do_col = 1'b1;
            end
        end
    end

    assign req_ready = do_col;

    // register the command, bank, multiplexed address and write word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NOP;
            dram_bank  <= '0;
            dram_addr  <= '0;
            dram_wdata <= '0;
        end else begin
            if (do_ref)       cmd_q <= CMD_REF;
            else if (do_pall) cmd_q <= CMD_PALL;
            else if (do_act)  cmd_q <= CMD_ACT;
            else if (do_pre)  cmd_q <= CMD_PRE;
            else if (do_col)  cmd_q <= req_write ? CMD_WR : CMD_RD;
            else              cmd_q <= CMD_NOP;
            dram_bank  <= r_bank;
            dram_addr  <= do_act ? DA_W'(r_row) : DA_W'(r_col);
            dram_wdata <= req_wdata;
        end
    end

    // column spacing on the data bus and refresh recovery time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_wait <= '0;
            rfc_wait <= '0;
        end else begin
            if (do_col)               col_wait <= req_write ? '0 : bl_cur - 1'b1;
            else if (col_wait != '0)  col_wait <= col_wait - 1'b1;
            if (do_ref)               rfc_wait <= TMR_W'(T_RFC - 1);
            else if (rfc_wait != '0)  rfc_wait <= rfc_wait - 1'b1;
        end
    end

    assign dram_cmd = cmd_q;

    // R9
    ref_banks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> (!any_open && !rd_busy));
    // R11
    wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WR) |-> !rd_busy);
    // R6
    hit_no_row_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ref_due && page_hit) |-> !(do_act || do_pre));
endmodule

// File: tb/sdc_ctrl_tb.sv
module sdc_ctrl_tb_top;
    localparam int CAS_LAT = 3;
    localparam int T_RCD   = 2;
    localparam int T_RP    = 2;
    localparam int REFI    = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_burst = 2'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [2:0]  dram_cmd;
    logic [1:0]  dram_bank;
    logic [7:0]  dram_addr;
    logic [15:0] dram_wdata;
    logic [15:0] dram_rdata = '0;

    sdc_ctrl #(.CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RP(T_RP), .REFI(REFI)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_cmd(dram_cmd), .dram_bank(dram_bank), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_act = 0, n_pre = 0, n_wr = 0, n_ref = 0, n_beats = 0, last_ref = -1;
    bit done = 0, act_in_rsp = 0;
    logic [15:0] exp_q[$];
    int          tim_q[$];
    logic [31:0] wr_q[$];
    bit          mopen [4];
    logic [7:0]  mrow [4];
    int          last_act [4], last_pre [4];
    bit          ring_v [32];
    logic [15:0] ring_d [32];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_addr(input int b, input int r, input int c);
        return {8'(r), 2'(b), 6'(c)};
    endfunction

    // expected beat k of a read: {bank, row, column+k wrapped}
    function automatic logic [15:0] exp_word(input logic [15:0] a, input int k);
        return {a[7:6], a[15:8], 6'(a[5:0] + 6'(k))};
    endfunction

    initial begin
        for (int b = 0; b < 4; b++) begin
            mopen[b] = 0; mrow[b] = '0; last_act[b] = -100; last_pre[b] = -100;
        end
        for (int i = 0; i < 32; i++) begin ring_v[i] = 0; ring_d[i] = '0; end
    end

    // monitor and DRAM model, all sampled at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (req_valid && req_ready) begin
                if (req_write) wr_q.push_back({req_addr, req_wdata});
                else for (int k = 0; k < (1 << cfg_burst); k++) exp_q.push_back(exp_word(req_addr, k));
            end
            if (rsp_valid) begin
                n_beats++;
                if (exp_q.size() == 0 || tim_q.size() == 0) chk(0, "R5 unexpected beat", int'(rsp_data), -1);
                else begin
                    logic [15:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = tim_q.pop_front();
                    chk(rsp_data == e, "R2 read data", int'(rsp_data), int'(e));
                    chk(cyc == t, "R4 beat timing", cyc, t);
                end
            end
            case (dram_cmd)
                3'd1: begin
                    n_act++;
                    if (rsp_valid) act_in_rsp = 1;
                    chk(!mopen[dram_bank], "R7 activate on open bank", int'(mopen[dram_bank]), 0);
                    chk(cyc - last_pre[dram_bank] >= T_RP, "R7 precharge gap", cyc - last_pre[dram_bank], T_RP);
                    mopen[dram_bank] = 1; mrow[dram_bank] = dram_addr; last_act[dram_bank] = cyc;
                end
                3'd2, 3'd3: begin
                    chk(mopen[dram_bank], "R2 column to closed bank", 0, 1);
                    chk(cyc - last_act[dram_bank] >= T_RCD, "R3 activate gap", cyc - last_act[dram_bank], T_RCD);
                    if (dram_cmd == 3'd2) begin
                        for (int k = 0; k < (1 << cfg_burst); k++) begin
                            ring_v[(cyc + CAS_LAT + k) % 32] = 1;
                            ring_d[(cyc + CAS_LAT + k) % 32] = {dram_bank, mrow[dram_bank], 6'(dram_addr[5:0] + 6'(k))};
                            tim_q.push_back(cyc + CAS_LAT + 1 + k);
                        end
                    end else begin
                        n_wr++;
                        chk(tim_q.size() == 0, "R11 write with read outstanding", tim_q.size(), 0);
                        if (wr_q.size() == 0) chk(0, "R11 unexpected write", 1, 0);
                        else begin
                            logic [31:0] w;
                            w = wr_q.pop_front();
                            chk({mrow[dram_bank], dram_bank, dram_addr[5:0]} == w[31:16], "R11 write address",
                                int'({mrow[dram_bank], dram_bank, dram_addr[5:0]}), int'(w[31:16]));
                            chk(dram_wdata == w[15:0], "R11 write data", int'(dram_wdata), int'(w[15:0]));
                        end
                    end
                end
                3'd4: begin n_pre++; mopen[dram_bank] = 0; last_pre[dram_bank] = cyc; end
                3'd5: for (int b = 0; b < 4; b++) begin mopen[b] = 0; last_pre[b] = cyc; end
                3'd6: begin
                    n_ref++;
                    chk(!(mopen[0] || mopen[1] || mopen[2] || mopen[3]), "R9 refresh with open bank", 1, 0);
                    chk(tim_q.size() == 0, "R9 refresh with read outstanding", tim_q.size(), 0);
                    if (last_ref >= 0) begin
                        chk(cyc - last_ref >= REFI - 30 && cyc - last_ref <= REFI + 30,
                            "R10 refresh period", cyc - last_ref, REFI);
                    end
                    last_ref = cyc;
                end
                default: ;
            endcase
            dram_rdata = ring_v[cyc % 32] ? ring_d[cyc % 32] : 16'h0;
            ring_v[cyc % 32] = 0;
        end
    end

    task automatic send(input bit wr, input int b, input int r, input int c, input logic [15:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = mk_addr(b, r, c); req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
        chk(exp_q.size() == 0, "R5 beats missing", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dram_cmd == 3'd0, "R1 idle in reset", int'(dram_cmd), 0);
        chk(!rsp_valid && !req_ready, "R1 strobes in reset", int'({rsp_valid, req_ready}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(dram_cmd == 3'd0 && !rsp_valid && !req_ready, "R1 first cycle", int'(dram_cmd), 0);
    endtask

    task automatic t_basic_read();
        int a0, b0;
        a0 = n_act; b0 = n_beats;
        cfg_burst = 2'd2;
        send(0, 1, 5, 8, '0);
        settle();
        chk(n_act - a0 == 1, "R2 one activate", n_act - a0, 1);
        chk(n_beats - b0 == 4, "R5 burst of four", n_beats - b0, 4);
    endtask

    task automatic t_page_hit();
        int a0, p0;
        a0 = n_act; p0 = n_pre;
        send(0, 1, 5, 16, '0);
        send(0, 1, 5, 40, '0);
        settle();
        chk(n_act == a0 && n_pre == p0, "R6 no row command on hit", n_act - a0 + n_pre - p0, 0);
    endtask

    task automatic t_row_miss();
        int a0, p0;
        a0 = n_act; p0 = n_pre;
        send(0, 1, 7, 2, '0);
        settle();
        chk(n_pre - p0 == 1, "R7 precharge on miss", n_pre - p0, 1);
        chk(n_act - a0 == 1, "R7 activate on miss", n_act - a0, 1);
    endtask

    task automatic t_pipeline();
        cfg_burst = 2'd3;
        act_in_rsp = 0;
        send(0, 2, 1, 0, '0);
        send(0, 3, 1, 0, '0);
        send(0, 0, 1, 0, '0);
        settle();
        chk(act_in_rsp, "R8 activate during burst", int'(act_in_rsp), 1);
    endtask

    task automatic t_write();
        int w0;
        w0 = n_wr;
        cfg_burst = 2'd3;
        send(0, 1, 7, 10, '0);
        send(1, 1, 9, 3, 16'hBEEF);
        send(1, 1, 9, 4, 16'h1234);
        settle();
        chk(n_wr - w0 == 2, "R11 write count", n_wr - w0, 2);
    endtask

    task automatic t_burst_lengths();
        for (int code = 0; code < 3; code++) begin
            int b0;
            b0 = n_beats;
            cfg_burst = 2'(code);
            send(0, 3, 1, 62, '0);
            settle();
            chk(n_beats - b0 == (1 << code), "R5 burst length", n_beats - b0, 1 << code);
        end
    endtask

    task automatic t_refresh_stream();
        int r0;
        r0 = n_ref;
        cfg_burst = 2'd3;
        for (int i = 0; i < 150; i++) send(0, 2, 4, i % 64, '0);
        settle();
        chk(n_ref - r0 >= 2, "R10 refresh under load", n_ref - r0, 2);
    endtask

    initial begin
        t_reset();
        t_basic_read();
        t_page_hit();
        t_row_miss();
        t_pipeline();
        t_write();
        t_burst_lengths();
        t_refresh_stream();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule